// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals and the index pulse of an incremental rotary or linear encoder into a 16-bit signed-direction position count. Each of the three encoder pins is synchronized to the system clock. It then passes through its own glitch filter. The filter accepts a new level only after that level has been seen on three consecutive ticks of a shared, programmable sampling divider.

The filtered phases drive a decoder in one of two resolutions. In x2 the decoder steps on both edges of phase A. In x4 it steps on every edge of either phase. The count then wraps in one of two ways. In max-count modes it wraps between zero and a programmable limit. In index modes it wraps over the full 16-bit range and is reset by the index pulse. Each wrap or index reset produces a one-cycle event pulse, and the direction of the last step is shown on a pin.

A simple synchronous register port configures the block and reads it back. Writes are captured on the clock edge. Reads are combinational from the read address.

Top module: `quad_pos_counter`

## Requirements
- R1: After reset the count reads 0x0000 and the limit reads 0xFFFF. The control register reads 0x0000, the status register reads 0x0001 (direction up, no error), and the event output is low.
- R2: In x4 modes (mode codes 3'b110 and 3'b111) every single-phase edge moves the count by one. An edge of A steps up when the new A differs from B. An edge of B steps up when the new B equals A. Otherwise the step is down.
- R3: In x2 modes (3'b100 and 3'b101) only edges of phase A move the count, by the same rule as R2. Edges of B alone are ignored.
- R4: The direction output is 1 after an up step and 0 after a down step, and it keeps that value until the next step. It also appears as bit 0 of the status register.
- R5: In max-count modes (3'b101, 3'b111) an up step from the limit gives 0, and a down step from 0 loads the limit. Each such wrap raises the event output for exactly one cycle.
- R6: In index modes (3'b100, 3'b110) a rising edge of the filtered index clears the count to 0 when the direction is up, and loads the limit when it is down. Each case gives a one-cycle event. Between index edges the count wraps freely between 0x0000 and 0xFFFF.
- R7: Mode codes 3'b000, 3'b001, 3'b010 and 3'b011 hold the count and the direction whatever the pins do.
- R8: In an enabled mode, a sample in which both filtered phases change leaves the count unchanged. It also sets a sticky error flag (status bit 1), which holds until any write to the status address.
- R9: A pin change reaches the decoder only after three consecutive equal samples taken on divider ticks. The divider select codes 0 to 7 give ticks every 1, 2, 4, 16, 32, 64, 128 and 256 cycles, so shorter pulses are dropped.
- R10: Register map. Address 0 is control: mode in bits 2:0, divider select in bits 6:4. Address 1 is the count, which can be written and read. Address 2 is the limit. Address 3 is status. A count write takes priority over a step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| encA | input | 1 | Encoder phase A pin |
| encB | input | 1 | Encoder phase B pin |
| encIdx | input | 1 | Encoder index pin |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 16 | Register read data (combinational) |
| dirOut | output | 1 | Direction of the last step, 1 = up |
| evtOut | output | 1 | One-cycle pulse on wrap or index reset |

## Verification
The embedded assertions check on every cycle that the decoder raises at most one of up, down and illegal, and that the direction follows each step. They also check that an illegal sample freezes the count, that wraps at the limit and at zero land on the right value with an event, that the error flag stays sticky, and that a filtered pin changes only on a divider tick. Only the bench scenarios can show the end-to-end counts produced by real Gray-code sequences in each resolution, glitch rejection at two divider settings, index resets in both directions, and that the idle mode codes ignore motion.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_COUNT = 2'd1;
  localparam logic [1:0] ADDR_LIMIT = 2'd2;
  localparam logic [1:0] ADDR_STAT  = 2'd3;

  // strobes from the decoder to the counter datapath
  typedef struct packed {
    logic stepUp;
    logic stepDn;
    logic idxClr;
    logic idxLoad;
    logic illegal;
  } qpcStrobe_t;

  // sampling-divider mask: tick when the free counter's low bits are zero
  function automatic logic [7:0] divMask(input logic [2:0] sel);
    logic [3:0] shift;
    case (sel)
      3'd0: shift = 4'd0;
      3'd1: shift = 4'd1;
      3'd2: shift = 4'd2;
      3'd3: shift = 4'd4;
      3'd4: shift = 4'd5;
      3'd5: shift = 4'd6;
      3'd6: shift = 4'd7;
      default: shift = 4'd8;
    endcase
    divMask = 8'((9'd1 << shift) - 9'd1);
  endfunction

endpackage

// File: rtl/qpc_filter.sv
module qpc_filter #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic pinIn,
  output logic pinOut
);

  logic [1:0]       syncQ;
  logic [DEPTH-1:0] hist;
  logic [DEPTH-1:0] histNext;

  assign histNext = {hist[DEPTH-2:0], syncQ[1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= '0;
      hist   <= '0;
      pinOut <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], pinIn};
      if (tick) begin
        hist <= histNext;
        if (&histNext)       pinOut <= 1'b1;
        else if (~|histNext) pinOut <= 1'b0;
      end
    end
  end

  // R9
  filt_tick_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pinOut) |-> $past(tick));

endmodule

// File: rtl/qpc_control.sv
module qpc_control
  import qpc_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] mode,
  input  logic [2:0] divSel,
  input  logic       fltA,
  input  logic       fltB,
  input  logic       fltIdx,
  output logic       tick,
  output logic       dirUp,
  output qpcStrobe_t stb
);

  logic [DIV_W-1:0] divCnt;
  logic             aPrev, bPrev, idxPrev;
  logic             aEdge, bEdge, idxRise;
  logic             enabled, quadMode, idxMode;

  assign tick     = (divCnt & DIV_W'(divMask(divSel))) == '0;
  assign aEdge    = fltA ^ aPrev;
  assign bEdge    = fltB ^ bPrev;
  assign idxRise  = fltIdx & ~idxPrev;
  assign enabled  = mode[2];
  assign quadMode = mode[1];
  assign idxMode  = ~mode[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      aPrev   <= 1'b0;
      bPrev   <= 1'b0;
      idxPrev <= 1'b0;
    end else begin
      divCnt  <= divCnt + 1'b1;
      aPrev   <= fltA;
      bPrev   <= fltB;
      idxPrev <= fltIdx;
    end
  end

  always_comb begin
    stb = '0;
    if (enabled) begin
      if (aEdge && bEdge) begin
        stb.illegal = 1'b1;
      end else if (aEdge) begin
        stb.stepUp = (fltA != fltB);
        stb.stepDn = (fltA == fltB);
      end else if (bEdge && quadMode) begin
        stb.stepUp = (fltB == fltA);
        stb.stepDn = (fltB != fltA);
      end
      if (idxMode && idxRise) begin
        stb.idxClr  = dirUp;
        stb.idxLoad = ~dirUp;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           dirUp <= 1'b1;
    else if (stb.stepUp) dirUp <= 1'b1;
    else if (stb.stepDn) dirUp <= 1'b0;
  end

  // R2
  one_step_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.stepUp, stb.stepDn, stb.illegal}));

  // R4
  dir_follows_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.stepDn |=> !dirUp);

  // R4
  dir_follows_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.stepUp |=> dirUp);

  // R7
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mode[2] |-> (stb == '0));

endmodule

// File: rtl/qpc_datapath.sv
module qpc_datapath
  import qpc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  qpcStrobe_t       stb,
  input  logic             limitMode,
  input  logic             wrCount,
  input  logic             wrLimit,
  input  logic             wrStat,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] limit,
  output logic             errFlag,
  output logic             evt
);

  logic [CNT_W-1:0] topVal;
  logic             anyIdx;

  assign topVal = limitMode ? limit : '1;
  assign anyIdx = stb.idxClr | stb.idxLoad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      evt   <= 1'b0;
    end else begin
      evt <= 1'b0;
      if (wrCount) begin
        count <= wrData;
      end else if (stb.idxClr) begin
        count <= '0;
        evt   <= 1'b1;
      end else if (stb.idxLoad) begin
        count <= limit;
        evt   <= 1'b1;
      end else if (stb.stepUp) begin
        if (count >= topVal) begin
          count <= '0;
          evt   <= 1'b1;
        end else begin
          count <= count + 1'b1;
        end
      end else if (stb.stepDn) begin
        if (count == '0) begin
          count <= topVal;
          evt   <= 1'b1;
        end else begin
          count <= count - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        limit <= '1;
    else if (wrLimit) limit <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            errFlag <= 1'b0;
    else if (stb.illegal) errFlag <= 1'b1;
    else if (wrStat)      errFlag <= 1'b0;
  end

  // R5
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepUp && limitMode && count == limit && !wrCount && !anyIdx)
      |=> (count == '0) && evt);

  // R5
  down_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepDn && count == '0 && !wrCount && !anyIdx)
      |=> (count == $past(topVal)) && evt);

  // R8
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.illegal && !wrCount && !anyIdx) |=> $stable(count));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !wrStat) |=> errFlag);

  // R6
  idx_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.idxClr && !wrCount) |=> (count == '0) && evt);

endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
  import qpc_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int DIV_W      = 8,
  parameter int FILT_DEPTH = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             encA,
  input  logic             encB,
  input  logic             encIdx,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       rdAddr,
  output logic [CNT_W-1:0] rdData,
  output logic             dirOut,
  output logic             evtOut
);

  localparam int NUM_PINS = 3;

  logic [NUM_PINS-1:0] pinRaw;
  logic [NUM_PINS-1:0] pinFlt;
  logic [2:0]          mode;
  logic [2:0]          divSel;
  logic                tick;
  logic                errFlag;
  logic [CNT_W-1:0]    count;
  logic [CNT_W-1:0]    limit;
  qpcStrobe_t          stb;

  assign pinRaw = {encIdx, encB, encA};

  for (genvar p = 0; p < NUM_PINS; p++) begin : gFilt
    qpc_filter #(.DEPTH(FILT_DEPTH)) uFilt (
      .clk(clk), .rstN(rstN), .tick(tick),
      .pinIn(pinRaw[p]), .pinOut(pinFlt[p])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode   <= '0;
      divSel <= '0;
    end else if (wrEn && wrAddr == ADDR_CTRL) begin
      mode   <= wrData[2:0];
      divSel <= wrData[6:4];
    end
  end

  qpc_control #(.DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .mode(mode), .divSel(divSel),
    .fltA(pinFlt[0]), .fltB(pinFlt[1]), .fltIdx(pinFlt[2]),
    .tick(tick), .dirUp(dirOut), .stb(stb)
  );

  qpc_datapath #(.CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb),
    .limitMode(mode[2] & mode[0]),
    .wrCount(wrEn && wrAddr == ADDR_COUNT),
    .wrLimit(wrEn && wrAddr == ADDR_LIMIT),
    .wrStat(wrEn && wrAddr == ADDR_STAT),
    .wrData(wrData), .count(count), .limit(limit),
    .errFlag(errFlag), .evt(evtOut)
  );

  always_comb begin
    case (rdAddr)
      ADDR_CTRL:  rdData = CNT_W'({divSel, 1'b0, mode});
      ADDR_COUNT: rdData = count;
      ADDR_LIMIT: rdData = limit;
      default:    rdData = CNT_W'({errFlag, dirOut});
    endcase
  end

endmodule

// File: tb/quad_pos_counter_test.sv
module quad_pos_counter_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        encA = 1'b0, encB = 1'b0, encIdx = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0, rdAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        dirOut, evtOut;

  int total = 0, bad = 0, evtSeen = 0;
  int encState = 0;

  quad_pos_counter uut (
    .clk(clk), .rstN(rstN), .encA(encA), .encB(encB), .encIdx(encIdx),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .dirOut(dirOut), .evtOut(evtOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rstN && evtOut) evtSeen++;

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    rdAddr = a;
    #1 d = rdData;
  endtask

  task automatic expectReg(input logic [1:0] a, input logic [15:0] exp, input string req);
    logic [15:0] v;
    readReg(a, v);
    check(v === exp, req, v, exp);
  endtask

  // Gray order of (A,B): 00,10,11,01 ; +1 is the up direction
  task automatic drivePhases();
    case (encState & 3)
      0: begin encA = 1'b0; encB = 1'b0; end
      1: begin encA = 1'b1; encB = 1'b0; end
      2: begin encA = 1'b1; encB = 1'b1; end
      default: begin encA = 1'b0; encB = 1'b1; end
    endcase
  endtask

  task automatic moveEnc(input int dir, input int n, input int hold);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      encState = (encState + dir) & 3;
      drivePhases();
      repeat (hold) @(negedge clk);
    end
  endtask

  task automatic pulseIdx();
    @(negedge clk); encIdx = 1'b1;
    repeat (12) @(negedge clk);
    encIdx = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic testReset();
    expectReg(2'd1, 16'h0000, "R1 count");
    expectReg(2'd2, 16'hFFFF, "R1 limit");
    expectReg(2'd0, 16'h0000, "R1 ctrl");
    expectReg(2'd3, 16'h0001, "R1 status");
    check(evtOut === 1'b0, "R1 evt", 16'(evtOut), 16'h0);
  endtask

  task automatic testX4();
    writeReg(2'd2, 16'd1000);
    writeReg(2'd0, 16'h0007);
    writeReg(2'd1, 16'd10);
    expectReg(2'd1, 16'd10, "R10 count write");
    moveEnc(1, 8, 12);
    expectReg(2'd1, 16'd18, "R2 x4 up");
    check(dirOut === 1'b1, "R4 dir up", 16'(dirOut), 16'h1);
    moveEnc(-1, 3, 12);
    expectReg(2'd1, 16'd15, "R2 x4 down");
    check(dirOut === 1'b0, "R4 dir down", 16'(dirOut), 16'h0);
    expectReg(2'd3, 16'h0000, "R4 status dir bit");
  endtask

  task automatic testX2();
    writeReg(2'd0, 16'h0005);
    expectReg(2'd0, 16'h0005, "R10 ctrl readback");
    writeReg(2'd1, 16'd0);
    moveEnc(1, 8, 12);
    expectReg(2'd1, 16'd4, "R3 x2 up");
    moveEnc(-1, 4, 12);
    expectReg(2'd1, 16'd2, "R3 x2 down");
  endtask

  task automatic testLimitWrap();
    int e0;
    writeReg(2'd0, 16'h0007);
    writeReg(2'd2, 16'd5);
    writeReg(2'd1, 16'd5);
    e0 = evtSeen;
    moveEnc(1, 1, 12);
    expectReg(2'd1, 16'd0, "R5 up wrap");
    check(evtSeen == e0 + 1, "R5 one event up", 16'(evtSeen - e0), 16'd1);
    moveEnc(-1, 1, 12);
    expectReg(2'd1, 16'd5, "R5 down wrap");
    check(evtSeen == e0 + 2, "R5 one event down", 16'(evtSeen - e0), 16'd2);
  endtask

  task automatic testIndex();
    int e0;
    writeReg(2'd2, 16'd100);
    writeReg(2'd0, 16'h0006);
    writeReg(2'd1, 16'd20);
    moveEnc(1, 2, 12);
    expectReg(2'd1, 16'd22, "R6 pre-index");
    e0 = evtSeen;
    pulseIdx();
    expectReg(2'd1, 16'd0, "R6 index clear");
    check(evtSeen == e0 + 1, "R6 index event", 16'(evtSeen - e0), 16'd1);
    moveEnc(-1, 3, 12);
    expectReg(2'd1, 16'hFFFD, "R6 full wrap");
    pulseIdx();
    expectReg(2'd1, 16'd100, "R6 index load");
  endtask

  task automatic testHold();
    writeReg(2'd0, 16'h0000);
    writeReg(2'd1, 16'd33);
    moveEnc(1, 4, 12);
    expectReg(2'd1, 16'd33, "R7 mode off");
    writeReg(2'd0, 16'h0001);
    moveEnc(-1, 4, 12);
    expectReg(2'd1, 16'd33, "R7 mode 001");
    writeReg(2'd0, 16'h0003);
    moveEnc(1, 2, 12);
    expectReg(2'd1, 16'd33, "R7 mode 011");
  endtask

  task automatic testIllegal();
    writeReg(2'd0, 16'h0007);
    writeReg(2'd2, 16'hFFFF);
    writeReg(2'd1, 16'd7);
    @(negedge clk);
    encState = (encState + 2) & 3;
    drivePhases();
    repeat (12) @(negedge clk);
    expectReg(2'd1, 16'd7, "R8 count held");
    expectReg(2'd3, 16'h0002 | 16'(dirOut), "R8 error set");
    moveEnc(1, 1, 12);
    expectReg(2'd3, 16'h0003, "R8 error sticky");
    writeReg(2'd3, 16'h0000);
    expectReg(2'd3, 16'h0001, "R8 error cleared");
  endtask

  task automatic testFilter();
    writeReg(2'd0, 16'h0007);
    writeReg(2'd1, 16'd0);
    @(negedge clk); encA = ~encA;
    repeat (2) @(negedge clk); encA = ~encA;
    repeat (20) @(negedge clk);
    expectReg(2'd1, 16'd0, "R9 short glitch div1");
    writeReg(2'd0, 16'h0037);
    repeat (40) @(negedge clk);
    @(negedge clk); encA = ~encA;
    repeat (20) @(negedge clk); encA = ~encA;
    repeat (100) @(negedge clk);
    expectReg(2'd1, 16'd0, "R9 glitch div16");
    moveEnc(1, 1, 80);
    expectReg(2'd1, 16'd1, "R9 accepted div16");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testX4();
    testX2();
    testLimitWrap();
    testIndex();
    testHold();
    testIllegal();
    testFilter();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule